// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block turns four asynchronous interrupt pins into latched interrupt flags and per-line requests toward a processor core. Every pin is first resynchronised to the core clock. Each line then applies its own sense setting: low level, any change, falling edge or rising edge. In the three edge settings a detected event sets the flag of that line, and the flag stays set until software or the interrupt sequencer clears it.

Software reads the flags through an 8-bit register. Bits 3..0 are the flags and bits 7..4 are reserved zeros. Software clears a flag by writing one to its bit. The core clears a flag in hardware by pulsing the acknowledge input of that line when it enters the handler. A line in low-level sense has no memory: its flag is held at zero and its request follows the synchronised pin directly. A request reaches the core only when the per-line enable and the global enable are both set.

Each line is controlled by a small state machine with three states:
- `LN_CLEAR`: no event is pending.
- `LN_PENDING`: the flag is set.
- `LN_LEVEL`: the line is in level sense and its flag is forced to zero.

The transitions are:
- `evt_set`: `LN_CLEAR` to `LN_PENDING` on an event.
- `sw_hw_clear`: `LN_PENDING` to `LN_CLEAR` on a write-one or an acknowledge with no event in the same cycle.
- `enter_level`: from either edge state to `LN_LEVEL` when the sense code becomes 00.
- `leave_level`: `LN_LEVEL` to `LN_CLEAR` when the sense code changes to any other value.
- `hold`: stay in the current state otherwise.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, all flags read as zero, the read data is zero and no request is asserted.
- R2: Read data bits 3..0 hold the flags of lines 3..0. Bits 7..4 always read as zero.
- R3: The sense code is 2 bits per line, in bits [2i+1:2i] of `sense_mode_i`. Code 01 sets the flag on either edge, 10 sets it on a falling edge only, and 11 sets it on a rising edge only. The flag becomes visible after the third rising clock edge following the pin change.
- R4: In an edge sense setting, `irq_req_o[i]` is high exactly when flag i, `line_en_i[i]` and `global_ie_i` are all high.
- R5: A one-cycle pulse on `ack_i[i]` clears flag i.
- R6: A write cycle clears each flag whose `bus_wdata_i` bit is one. Zero bits and bits 7..4 have no effect.
- R7: While a line's sense code is 00, its flag reads zero, and any pending flag is dropped on the next clock edge.
- R8: With sense code 00, `irq_req_o[i]` is high when the synchronised pin is low and the line enable and the global enable are both high.
- R9: When an event and a clear (write-one or acknowledge) occur in the same cycle, the flag ends up set.
- R10: Without an event, a clear or a change of sense code, a flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| sense_mode_i | input | 8 | 2-bit sense code per line (00 low, 01 any, 10 fall, 11 rise) |
| line_en_i | input | 4 | Per-line request enable |
| global_ie_i | input | 1 | Global interrupt enable |
| bus_wr_i | input | 1 | Flag register write strobe |
| bus_wdata_i | input | 8 | Write data; a one clears the matching flag |
| bus_rdata_o | output | 8 | Flag register read value |
| ack_i | input | 4 | Per-line vector-taken acknowledge |
| irq_req_o | output | 4 | Per-line interrupt request |

## Verification
Several rules are checked by the assertions on every cycle for every line:
- The flag is zero while level sense is selected.
- Clears take effect when no event coincides.
- An event always leaves the flag set, even against a clear.
- An idle flag holds its value.
- Edge-mode requests follow the flag and the enable gating.

Only the bench's scenarios can show the parts that involve the pins directly. These are the synchroniser latency, the polarity each sense code selects, the level request following the pin, and the ignored write bits.

// File: rtl/eif_pkg.sv
`timescale 1ns/1ps
package eif_pkg;

    // Per-line sense code; the encoding is visible on the sense_mode_i port.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Per-line flag state.
    typedef enum logic [1:0] {
        LN_CLEAR   = 2'b00,
        LN_PENDING = 2'b01,
        LN_LEVEL   = 2'b10
    } line_state_e;

endpackage

// File: rtl/eif_sync.sv
`timescale 1ns/1ps
module eif_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/eif_event_detect.sv
`timescale 1ns/1ps
module eif_event_detect
    import eif_pkg::*;
#(
    parameter int NUM_LINES = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_LINES-1:0]   sync_i,
    input  logic [2*NUM_LINES-1:0] mode_i,
    output logic [NUM_LINES-1:0]   event_o,
    output logic [NUM_LINES-1:0]   level_mode_o,
    output logic [NUM_LINES-1:0]   level_low_o
);

    logic [NUM_LINES-1:0] prev_q;

    // The previous synchronised sample is tracked in every mode, so a mode
    // change never produces a stale edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_i;
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        sense_e mode;
        logic   rise;
        logic   fall;

        assign mode = sense_e'(mode_i[2*i +: 2]);
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];

        always_comb begin
            unique case (mode)
                SENSE_LOW:  event_o[i] = 1'b0;
                SENSE_ANY:  event_o[i] = rise | fall;
                SENSE_FALL: event_o[i] = fall;
                SENSE_RISE: event_o[i] = rise;
                default:    event_o[i] = 1'b0;
            endcase
        end

        assign level_mode_o[i] = (mode == SENSE_LOW);
        assign level_low_o[i]  = (mode == SENSE_LOW) & ~sync_i[i];
    end

endmodule

// File: rtl/eif_line_fsm.sv
`timescale 1ns/1ps
module eif_line_fsm
    import eif_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_mode_i,
    input  logic event_i,
    input  logic clear_i,
    output logic flag_o
);

    line_state_e state_q;
    line_state_e state_d;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LN_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: enter_level, leave_level, evt_set, sw_hw_clear, hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_LEVEL: begin
                if (!level_mode_i) begin
                    state_d = LN_CLEAR;        // leave_level
                end
            end
            LN_CLEAR: begin
                if (level_mode_i) begin
                    state_d = LN_LEVEL;        // enter_level
                end else if (event_i) begin
                    state_d = LN_PENDING;      // evt_set
                end
            end
            LN_PENDING: begin
                if (level_mode_i) begin
                    state_d = LN_LEVEL;        // enter_level
                end else if (!event_i && clear_i) begin
                    state_d = LN_CLEAR;        // sw_hw_clear (event wins)
                end
            end
            default: state_d = LN_CLEAR;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            LN_PENDING: flag_o = 1'b1;
            LN_CLEAR:   flag_o = 1'b0;
            LN_LEVEL:   flag_o = 1'b0;
            default:    flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ext_irq_flags.sv
`timescale 1ns/1ps
module ext_irq_flags
    import eif_pkg::*;
#(
    parameter int NUM_LINES   = 4,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_LINES-1:0]   pin_i,
    input  logic [2*NUM_LINES-1:0] sense_mode_i,
    input  logic [NUM_LINES-1:0]   line_en_i,
    input  logic                   global_ie_i,
    input  logic                   bus_wr_i,
    input  logic [REG_W-1:0]       bus_wdata_i,
    output logic [REG_W-1:0]       bus_rdata_o,
    input  logic [NUM_LINES-1:0]   ack_i,
    output logic [NUM_LINES-1:0]   irq_req_o
);

    localparam int RSVD_W = REG_W - NUM_LINES;

    logic [NUM_LINES-1:0] pin_sync;
    logic [NUM_LINES-1:0] line_evt;
    logic [NUM_LINES-1:0] level_mode;
    logic [NUM_LINES-1:0] level_low;
    logic [NUM_LINES-1:0] flag;
    logic [NUM_LINES-1:0] clr;
    logic                 unused_wdata_hi;

    eif_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eif_event_detect #(
        .NUM_LINES (NUM_LINES)
    ) u_detect (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sync_i       (pin_sync),
        .mode_i       (sense_mode_i),
        .event_o      (line_evt),
        .level_mode_o (level_mode),
        .level_low_o  (level_low)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign clr[i] = ack_i[i] | (bus_wr_i & bus_wdata_i[i]);

        eif_line_fsm u_fsm (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .level_mode_i (level_mode[i]),
            .event_i      (line_evt[i]),
            .clear_i      (clr[i]),
            .flag_o       (flag[i])
        );

        assign irq_req_o[i] = global_ie_i & line_en_i[i]
                            & (level_mode[i] ? level_low[i] : flag[i]);
    end

    assign bus_rdata_o     = {{RSVD_W{1'b0}}, flag};
    assign unused_wdata_hi = ^bus_wdata_i[REG_W-1:NUM_LINES];

endmodule

// File: rtl/eif_checker.sv
`timescale 1ns/1ps
module eif_checker #(
    parameter int NUM_LINES = 4,
    parameter int REG_W     = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [2*NUM_LINES-1:0] sense_mode_i,
    input logic [NUM_LINES-1:0]   line_en_i,
    input logic                   global_ie_i,
    input logic                   bus_wr_i,
    input logic [NUM_LINES-1:0]   wdata_lo_i,
    input logic [REG_W-1:0]       bus_rdata_i,
    input logic [NUM_LINES-1:0]   ack_i,
    input logic [NUM_LINES-1:0]   irq_req_i,
    input logic [NUM_LINES-1:0]   evt_i
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        logic lvl;
        logic clr;
        assign lvl = (sense_mode_i[2*i +: 2] == 2'b00);
        assign clr = ack_i[i] | (bus_wr_i & wdata_lo_i[i]);

        // R7
        level_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            lvl |=> !bus_rdata_i[i]);

        // R5
        ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ack_i[i] && !evt_i[i]) |=> !bus_rdata_i[i]);

        // R6
        wr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (bus_wr_i && wdata_lo_i[i] && !evt_i[i]) |=> !bus_rdata_i[i]);

        // R9
        set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (evt_i[i] && !lvl) |=> bus_rdata_i[i]);

        // R10
        flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!evt_i[i] && !clr && !lvl) |=> $stable(bus_rdata_i[i]));

        // R4
        edge_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lvl |-> (irq_req_i[i] == (bus_rdata_i[i] & line_en_i[i] & global_ie_i)));
    end

endmodule

bind ext_irq_flags eif_checker #(
    .NUM_LINES (NUM_LINES),
    .REG_W     (REG_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sense_mode_i (sense_mode_i),
    .line_en_i    (line_en_i),
    .global_ie_i  (global_ie_i),
    .bus_wr_i     (bus_wr_i),
    .wdata_lo_i   (bus_wdata_i[NUM_LINES-1:0]),
    .bus_rdata_i  (bus_rdata_o),
    .ack_i        (ack_i),
    .irq_req_i    (irq_req_o),
    .evt_i        (line_evt)
);

// File: tb/sim_ext_irq_flags.sv
`timescale 1ns/1ps
module sim_ext_irq_flags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = '0;
    logic [7:0] mode = 8'hFF;
    logic [3:0] en = 4'hF;
    logic       gie = 1'b1;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] ack = '0;
    logic [3:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ext_irq_flags u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pin_i        (pin),
        .sense_mode_i (mode),
        .line_en_i    (en),
        .global_ie_i  (gie),
        .bus_wr_i     (wr),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .ack_i        (ack),
        .irq_req_o    (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        wr = 1'b1; wdata = d;
        cyc(1);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 rdata", rdata, 8'h00);
        check("R1 irq", {4'h0, irq}, 8'h00);
    endtask

    task automatic t_rise;
        pin[0] = 1'b1;
        cyc(2);
        check("R3 latency before third edge", {7'h0, rdata[0]}, 8'h00);
        cyc(1);
        check("R3 rising sets", rdata, 8'h01);
        check("R4 request", {4'h0, irq}, 8'h01);
        bus_write(8'h01);
        check("R6 write one clears", rdata, 8'h00);
        pin[0] = 1'b0;
        cyc(4);
        check("R3 falling ignored in rise mode", rdata, 8'h00);
    endtask

    task automatic t_fall_ack;
        mode[3:2] = 2'b10;
        pin[1] = 1'b1;
        cyc(4);
        check("R3 rising ignored in fall mode", rdata, 8'h00);
        pin[1] = 1'b0;
        cyc(3);
        check("R3 falling sets", rdata, 8'h02);
        ack = 4'b0010;
        cyc(1);
        ack = '0;
        check("R5 ack clears", rdata, 8'h00);
    endtask

    task automatic t_any_write;
        mode[5:4] = 2'b01;
        pin[2] = 1'b1;
        cyc(3);
        check("R3 any-change rising", rdata, 8'h04);
        bus_write(8'h04);
        pin[2] = 1'b0;
        cyc(3);
        check("R3 any-change falling", rdata, 8'h04);
        bus_write(8'hFB);
        check("R6 zero bits and 7..4 ignored", rdata, 8'h04);
        check("R2 reserved read zero", {4'h0, rdata[7:4]}, 8'h00);
        cyc(5);
        check("R10 flag holds", rdata, 8'h04);
        en[2] = 1'b0; #1;
        check("R4 line disable masks", {4'h0, irq}, 8'h00);
        en[2] = 1'b1; gie = 1'b0; #1;
        check("R4 global disable masks", {4'h0, irq}, 8'h00);
        gie = 1'b1; #1;
        check("R4 request restored", {4'h0, irq}, 8'h04);
        cyc(1);
        bus_write(8'h04);
        check("R6 cleared", rdata, 8'h00);
    endtask

    task automatic t_set_wins;
        pin[3] = 1'b1;
        cyc(2);
        ack = 4'b1000; wr = 1'b1; wdata = 8'h08;
        cyc(1);
        ack = '0; wr = 1'b0; wdata = '0;
        check("R9 set wins over clear", rdata, 8'h08);
        bus_write(8'h08);
        check("R6 cleared after R9", rdata, 8'h00);
    endtask

    task automatic t_level;
        pin[0] = 1'b1;
        cyc(3);
        check("R3 rise before level", rdata, 8'h01);
        mode[1:0] = 2'b00;
        cyc(1);
        check("R7 pending flag dropped", rdata, 8'h00);
        check("R8 high pin no request", {4'h0, irq}, 8'h00);
        pin[0] = 1'b0;
        cyc(1);
        check("R8 not yet synchronised", {4'h0, irq}, 8'h00);
        cyc(1);
        check("R8 low pin requests", {4'h0, irq}, 8'h01);
        check("R7 flag zero in level", rdata, 8'h00);
        en[0] = 1'b0; #1;
        check("R8 enable gates level", {4'h0, irq}, 8'h00);
        en[0] = 1'b1;
        pin[0] = 1'b1;
        cyc(3);
        check("R7 edges ignored in level", rdata, 8'h00);
        check("R8 request follows pin", {4'h0, irq}, 8'h00);
        mode[1:0] = 2'b11;
        cyc(3);
        check("R10 no flag after leaving level", rdata, 8'h00);
    endtask

    initial begin
        cyc(3);
        t_reset;
        rst_n = 1'b1;
        cyc(2);
        t_reset;
        t_rise;
        t_fall_ack;
        t_any_write;
        t_set_wins;
        t_level;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule